// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Flags

This block keeps the eight-bit status byte that a position sensor interface places at the head of every response. It follows two kinds of event, a zero-position capture and a wrap of the multi-cycle counter across a 4096-cycle boundary. Each event has an "occurred" flag and a paired "lost" flag. The "lost" flag records that the event came again before the host acknowledged the first one. Reads acknowledge the flags, and each event has its own kind of read. There is no write-one-to-clear path.

The block also reduces a vector of fatal-fault sources to one summary bit. It holds the interpolator disabled after any fault until a restart command arrives, and it drives an active-low interrupt line from the enabled pending events and the fault summary. The surrounding logic supplies the event pulses, the counter samples, the clear strobes and the enables. It reads the status byte, the interrupt line and the disable output.

Top module: `evt_status_irq`

## Requirements
- R1: The status byte is laid out as: bit 5 fatal fault, bit 4 interrupt request, bit 3 capture lost, bit 2 capture occurred, bit 1 wrap lost, bit 0 wrap occurred. Bits 7:6 always read 0.
- R2: Bit 5 is the OR of all `fault_vec` bits and follows `fault_vec` in the same cycle.
- R3: `interp_off` rises on the clock edge at which any `fault_vec` bit is set. It stays high until an edge where `restart` is high and `fault_vec` is zero. A restart while a fault is present keeps it high.
- R4: A `cap_evt` pulse sets bit 2 at the next edge. `cap_read_clr` clears it. `pos_read_clr` has no effect on it.
- R5: A `cap_evt` that arrives while bit 2 is already set also sets bit 3. Bit 3 clears together with bit 2 on `cap_read_clr`, and bit 3 is never set while bit 2 is clear.
- R6: A wrap event is a `cnt_valid` sample whose bits 13:12 differ from those of the previous accepted sample. This covers counting up, counting down and wrapping through 0. A wrap event sets bit 0. The first sample after reset only loads the reference and raises no event.
- R7: A wrap event that arrives while bit 0 is set also sets bit 1.
- R8: `pos_read_clr` clears bits 1 and 0. `cap_read_clr` has no effect on them.
- R9: When an event and its clear strobe come in the same cycle, the event wins: the "occurred" flag stays set. If it was already set, the "lost" flag is set too.
- R10: Bit 4 = bit 5 OR (bit 2 AND `cap_irq_en`) OR (bit 0 AND `roll_irq_en`). `irq_n` is the inverse of bit 4. The enables change no flag.
- R11: After reset all flags are 0, `interp_off` is 0, and with no fault present `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_evt | input | 1 | Zero-position capture pulse |
| cnt_valid | input | 1 | New multi-cycle counter sample present |
| cnt_val | input | 14 | Multi-cycle counter sample |
| fault_vec | input | 8 | Fatal fault sources, level |
| cap_irq_en | input | 1 | Capture flag may request an interrupt |
| roll_irq_en | input | 1 | Wrap flag may request an interrupt |
| cap_read_clr | input | 1 | Captured position was read |
| pos_read_clr | input | 1 | Position was read |
| restart | input | 1 | Restart command for the interpolator |
| status | output | 8 | Status byte |
| irq_n | output | 1 | Active-low interrupt request |
| interp_off | output | 1 | Interpolator disabled |

## Verification
The assertions assume that an event and a clear strobe are single-cycle pulses sampled at the clock edge. They also assume that `cnt_val` is only meaningful while `cnt_valid` is high, and that `fault_vec` is a level that may persist for many cycles. The stimulus drives every pulse for exactly one cycle and lets the counter move in small up and down steps, with occasional jumps across several 4096 boundaries. The fault vector is held for stretches so that restart is seen both with and without a fault present. The directed part forces the same-cycle event and clear cases, and a long pseudo-random phase mixes all inputs.

// File: rtl/evt_status_irq.sv
module evt_status_irq #(
  parameter int CNT_W    = 14,
  parameter int WRAP_LSB = 12,
  parameter int FLT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic             cnt_valid,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [FLT_W-1:0] fault_vec,
  input  logic             cap_irq_en,
  input  logic             roll_irq_en,
  input  logic             cap_read_clr,
  input  logic             pos_read_clr,
  input  logic             restart,
  output logic [7:0]       status,
  output logic             irq_n,
  output logic             interp_off
);
  logic [CNT_W-1:0] prev_cnt;
  logic primed, zc_q, zcl_q, mcr_q, mcrl_q, off_q;
  logic any_flt, roll_evt, irq_req;

  assign any_flt  = |fault_vec;
  assign roll_evt = cnt_valid && primed &&
                    ((cnt_val >> WRAP_LSB) != (prev_cnt >> WRAP_LSB));
  assign irq_req  = any_flt | (zc_q & cap_irq_en) | (mcr_q & roll_irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cnt <= '0;
      primed   <= 1'b0;
    end else if (cnt_valid) begin
      prev_cnt <= cnt_val;
      primed   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q  <= 1'b0;
      zcl_q <= 1'b0;
    end else begin
      if (cap_evt)           zc_q  <= 1'b1;
      else if (cap_read_clr) zc_q  <= 1'b0;
      if (cap_evt && zc_q)   zcl_q <= 1'b1;
      else if (cap_read_clr) zcl_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcr_q  <= 1'b0;
      mcrl_q <= 1'b0;
    end else begin
      if (roll_evt)           mcr_q  <= 1'b1;
      else if (pos_read_clr)  mcr_q  <= 1'b0;
      if (roll_evt && mcr_q)  mcrl_q <= 1'b1;
      else if (pos_read_clr)  mcrl_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= 1'b0;
    else if (any_flt) off_q <= 1'b1;
    else if (restart) off_q <= 1'b0;
  end

  assign status     = {2'b00, any_flt, irq_req, zcl_q, zc_q, mcrl_q, mcr_q};
  assign irq_n      = ~irq_req;
  assign interp_off = off_q;
endmodule

module evt_status_irq_chk #(
  parameter int FLT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_evt,
  input logic             roll_evt,
  input logic [FLT_W-1:0] fault_vec,
  input logic             cap_read_clr,
  input logic             pos_read_clr,
  input logic             restart,
  input logic [7:0]       status,
  input logic             irq_n,
  input logic             interp_off
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status[7:6] == 2'b00); // R1
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (|fault_vec) |=> interp_off); // R3
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (interp_off && !restart) |=> interp_off); // R3
  AST_CAP_SET: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |=> status[2]); // R4
  AST_CAP_CLR: assert property (@(posedge clk) disable iff (!rst_n) (cap_read_clr && !cap_evt) |=> !status[2] && !status[3]); // R5
  AST_CAP_LOST: assert property (@(posedge clk) disable iff (!rst_n) (cap_evt && status[2]) |=> status[3]); // R5
  AST_LOST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) status[3] |-> status[2]); // R5
  AST_ROLL_SET: assert property (@(posedge clk) disable iff (!rst_n) roll_evt |=> status[0]); // R6
  AST_ROLL_LOST: assert property (@(posedge clk) disable iff (!rst_n) (roll_evt && status[0]) |=> status[1]); // R7
  AST_POS_CLR: assert property (@(posedge clk) disable iff (!rst_n) (pos_read_clr && !roll_evt) |=> !status[0] && !status[1]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (cap_evt && cap_read_clr) |=> status[2]); // R9
  AST_IRQ_PIN: assert property (@(posedge clk) disable iff (!rst_n) irq_n == !status[4]); // R10
  AST_FLT_IRQ: assert property (@(posedge clk) disable iff (!rst_n) status[5] |-> status[4]); // R10
endmodule

bind evt_status_irq evt_status_irq_chk #(.FLT_W(FLT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .roll_evt(roll_evt),
  .fault_vec(fault_vec), .cap_read_clr(cap_read_clr), .pos_read_clr(pos_read_clr),
  .restart(restart), .status(status), .irq_n(irq_n), .interp_off(interp_off)
);

// File: tb/sim_evt_status_irq.sv
`timescale 1ns/1ps
module sim_evt_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_evt = 0, cnt_valid = 0, cap_irq_en = 0, roll_irq_en = 0;
  logic cap_read_clr = 0, pos_read_clr = 0, restart = 0;
  logic [13:0] cnt_val = '0;
  logic [7:0] fault_vec = '0;
  logic [7:0] status;
  logic irq_n, interp_off;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_zc, m_zcl, m_mcr, m_mcrl, m_off, m_primed;
  int m_prev_blk;

  always #4 clk = ~clk;

  evt_status_irq u0 (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cnt_valid(cnt_valid),
    .cnt_val(cnt_val), .fault_vec(fault_vec), .cap_irq_en(cap_irq_en),
    .roll_irq_en(roll_irq_en), .cap_read_clr(cap_read_clr),
    .pos_read_clr(pos_read_clr), .restart(restart), .status(status),
    .irq_n(irq_n), .interp_off(interp_off)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit wrap;
    int blk;
    if (!rst_n) begin
      m_zc = 0; m_zcl = 0; m_mcr = 0; m_mcrl = 0; m_off = 0;
      m_primed = 0; m_prev_blk = 0;
      return;
    end
    blk = int'(cnt_val) / 4096;
    wrap = cnt_valid && m_primed && (blk != m_prev_blk);
    if (cnt_valid) begin m_primed = 1; m_prev_blk = blk; end
    if (cap_evt && m_zc) m_zcl = 1; else if (cap_read_clr) m_zcl = 0;
    if (cap_evt) m_zc = 1; else if (cap_read_clr) m_zc = 0;
    if (wrap && m_mcr) m_mcrl = 1; else if (pos_read_clr) m_mcrl = 0;
    if (wrap) m_mcr = 1; else if (pos_read_clr) m_mcr = 0;
    if (fault_vec != 0) m_off = 1; else if (restart) m_off = 0;
  endtask

  task automatic compare();
    bit f, irq;
    f = (fault_vec != 0);
    irq = f || (m_zc && cap_irq_en) || (m_mcr && roll_irq_en);
    chk("R1 reserved bits", int'(status[7:6]), 0);
    chk("R2 fatal summary", int'(status[5]), int'(f));
    chk("R10 irq bit", int'(status[4]), int'(irq));
    chk("R10 irq_n pin", int'(irq_n), int'(!irq));
    chk("R5 capture lost", int'(status[3]), int'(m_zcl));
    chk("R4 capture flag", int'(status[2]), int'(m_zc));
    chk("R7 wrap lost", int'(status[1]), int'(m_mcrl));
    chk("R6 wrap flag", int'(status[0]), int'(m_mcr));
    chk("R3 interp_off", int'(interp_off), int'(m_off));
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    compare();
    cap_evt = 0; cnt_valid = 0; cap_read_clr = 0; pos_read_clr = 0; restart = 0;
  endtask

  task automatic sample(int v);
    cnt_valid = 1; cnt_val = 14'(v);
  endtask

  initial begin
    repeat (3) cyc();
    chk("R11 reset status", int'(status[5:0]), 0);
    chk("R11 reset irq_n", int'(irq_n), 1);
    chk("R11 reset off", int'(interp_off), 0);
    rst_n = 1;
    cyc();

    // capture flags
    cap_evt = 1; cyc(); chk("R4 set", int'(status[2]), 1);
    cap_evt = 1; cyc(); chk("R5 lost set", int'(status[3]), 1);
    pos_read_clr = 1; cyc(); chk("R4 pos read ignored", int'(status[3:2]), 3);
    cap_read_clr = 1; cyc(); chk("R5 cleared", int'(status[3:2]), 0);

    // wrap detection
    sample(4090); cyc(); chk("R6 first sample no event", int'(status[0]), 0);
    sample(4100); cyc(); chk("R6 up crossing", int'(status[0]), 1);
    sample(4101); cyc(); chk("R7 no second wrap", int'(status[1]), 0);
    sample(4000); cyc(); chk("R7 down crossing lost", int'(status[1]), 1);
    cap_read_clr = 1; cyc(); chk("R8 capture read ignored", int'(status[1:0]), 3);
    pos_read_clr = 1; cyc(); chk("R8 cleared", int'(status[1:0]), 0);
    sample(16383); cyc(); pos_read_clr = 1; cyc();
    sample(0); cyc(); chk("R6 wrap through zero", int'(status[0]), 1);
    pos_read_clr = 1; sample(1); cyc(); chk("R8 clear no wrap", int'(status[0]), 0);

    // set wins
    cap_evt = 1; cyc();
    cap_evt = 1; cap_read_clr = 1; cyc();
    chk("R9 set wins flag", int'(status[2]), 1);
    chk("R9 set wins lost", int'(status[3]), 1);
    sample(8192); pos_read_clr = 1; cyc(); chk("R9 wrap beats clear", int'(status[0]), 1);
    cap_read_clr = 1; pos_read_clr = 1; cyc();

    // interrupt enables
    cap_irq_en = 1; cap_evt = 1; cyc(); chk("R10 capture irq", int'(irq_n), 0);
    cap_read_clr = 1; cyc(); chk("R10 irq released", int'(irq_n), 1);
    cap_irq_en = 0; cap_evt = 1; cyc(); chk("R10 disabled no irq", int'(irq_n), 1);
    chk("R10 flag still set", int'(status[2]), 1);
    cap_read_clr = 1; cyc();

    // fault / restart
    fault_vec = 8'h10; cyc(); chk("R3 off after fault", int'(interp_off), 1);
    chk("R2 fault bit", int'(status[5]), 1);
    fault_vec = 0; cyc(); chk("R3 held", int'(interp_off), 1);
    fault_vec = 8'h04; restart = 1; cyc(); chk("R3 restart blocked", int'(interp_off), 1);
    fault_vec = 0; restart = 1; cyc(); chk("R3 restart", int'(interp_off), 0);

    // pseudo-random mix
    begin
      int c;
      c = 1;
      for (int i = 0; i < 4000; i++) begin
        int r;
        r = int'($urandom_range(0, 99));
        cap_evt      = (r < 12);
        cap_read_clr = ($urandom_range(0, 9) == 0);
        pos_read_clr = ($urandom_range(0, 9) == 0);
        restart      = ($urandom_range(0, 19) == 0);
        if ($urandom_range(0, 49) == 0) cap_irq_en = ~cap_irq_en;
        if ($urandom_range(0, 49) == 0) roll_irq_en = ~roll_irq_en;
        if ($urandom_range(0, 99) == 0) fault_vec = 8'($urandom_range(0, 255));
        else if ($urandom_range(0, 29) == 0) fault_vec = 0;
        if ($urandom_range(0, 2) != 0) begin
          if ($urandom_range(0, 19) == 0) c = int'($urandom_range(0, 16383));
          else c = (c + int'($urandom_range(0, 400)) - 200 + 16384) % 16384;
          sample(c);
        end
        cyc();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule